// File: doc/BRIEF.md
# Graded Phase-Slip Detector

This block watches the phase-error pulse that a PLL phase detector produces and records how wide the worst pulse has been since the last readout. It measures the width of each pulse by counting cycles of the crystal reference clock while the pulse is high. It keeps four sticky flags, one for each fixed width threshold. The result is a coarse grading of how far the loop has slipped, not a single lock or unlock bit.

The phase-error pulse is asynchronous to the reference clock, so it first passes through a flop synchronizer. A run counter then tracks how many consecutive cycles the synchronized pulse has been high. The counter goes back to zero on any low cycle and saturates rather than wrapping.

Each flag sets when the count goes past its threshold and stays set until the clear strobe. The clear strobe is issued when the status snapshot is taken. With a 7.2 MHz reference, the default thresholds of 4, 8, 16 and 24 cycles stand for roughly 0.55, 1.11, 2.22 and 3.33 µs.

Top module: `phase_slip_grader`

## Requirements
- R1: A flag sets once the synchronized error pulse has been high for more than its threshold number of consecutive reference cycles. The flag positions are bit 3 for 4 cycles, bit 0 for 8 cycles, bit 1 for 16 cycles and bit 2 for 24 cycles.
- R2: A pulse whose synchronized width is at or below a threshold leaves that flag clear. A pulse of W cycles at `err_in` is seen as W cycles after the synchronizer.
- R3: A set flag stays set on every cycle where `snap_clr` is low, whatever `err_in` does.
- R4: A one-cycle `snap_clr` while no error pulse is being counted returns all flags to 0 on the next cycle.
- R5: The flags are always nested. Bit 2 implies bit 1, bit 1 implies bit 0, and bit 0 implies bit 3.
- R6: When `snap_clr` coincides with a count that is above a threshold, the set wins: that flag reads 1 after the clear.
- R7: The run counter saturates and does not wrap. A clear issued during a very long pulse is followed at once by all four flags set.
- R8: Two short pulses separated by at least one low cycle are not added together. The count restarts from zero.
- R9: After reset all flags read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Crystal reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| err_in | input | 1 | Phase-error pulse, asynchronous, high while the phase error is present |
| snap_clr | input | 1 | One-cycle strobe that clears the sticky flags when the snapshot is taken |
| slip_flag | output | 4 | Sticky width flags, bit positions as listed in R1 |

## Verification
The bench builds the block with its default parameters: thresholds of 4, 8, 16 and 24 cycles and a two-stage synchronizer. With these values a few dozen cycles of stimulus reach every threshold, both at its exact value and one cycle past it. Pulses of a couple of hundred cycles are long enough to drive the counter into saturation, so the saturation behaviour of R7 is exercised directly.

// File: rtl/psg_pkg.sv
package psg_pkg;
   localparam int NBINS = 4;
   typedef logic [NBINS-1:0] flag_vec_t;
endpackage

// File: rtl/psg_sync.sv
module psg_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   generate
      if (STAGES < 2) begin : g_bad
         $error("psg_sync: STAGES must be at least 2");
      end
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[i] <= 1'b0;
            else        chain[i] <= (i == 0) ? d : chain[(i == 0) ? 0 : i - 1];
         end
      end
   endgenerate

   assign q = chain[STAGES-1];
endmodule

// File: rtl/psg_run_ctr.sv
module psg_run_ctr #(
   parameter int CNT_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             active,
   output logic [CNT_W-1:0] count
);
   localparam logic [CNT_W-1:0] SAT = {CNT_W{1'b1}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)           count <= '0;
      else if (!active)     count <= '0;
      else if (count != SAT) count <= count + 1'b1;
   end
endmodule

// File: rtl/psg_bin.sv
module psg_bin #(
   parameter int CNT_W = 5,
   parameter int TH    = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic [CNT_W-1:0] count,
   output logic             flag
);
   localparam logic [CNT_W-1:0] TH_V = CNT_W'(TH);
   logic hit;

   assign hit = (count > TH_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag <= 1'b0;
      else        flag <= (flag & ~clr) | hit;
   end
endmodule

// File: rtl/phase_slip_grader.sv
module phase_slip_grader
   import psg_pkg::*;
#(
   parameter int TH_B0       = 8,
   parameter int TH_B1       = 16,
   parameter int TH_B2       = 24,
   parameter int TH_B3       = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       err_in,
   input  logic       snap_clr,
   output logic [3:0] slip_flag
);
   function automatic int th_of(input int idx);
      case (idx)
         0:       return TH_B0;
         1:       return TH_B1;
         2:       return TH_B2;
         default: return TH_B3;
      endcase
   endfunction

   localparam int MAX_TH = TH_B2;
   localparam int CNT_W  = $clog2(MAX_TH + 2);

   generate
      if (!(TH_B3 > 0 && TH_B3 < TH_B0 && TH_B0 < TH_B1 && TH_B1 < TH_B2)) begin : g_order_bad
         $error("phase_slip_grader: thresholds must rise B3 < B0 < B1 < B2");
      end
      if ((2 ** CNT_W) - 1 <= MAX_TH) begin : g_width_bad
         $error("phase_slip_grader: counter cannot pass the top threshold");
      end
   endgenerate

   logic             err_s;
   logic [CNT_W-1:0] run_cnt;
   flag_vec_t        flags;

   psg_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (err_in),
      .q     (err_s)
   );

   psg_run_ctr #(.CNT_W(CNT_W)) u_ctr (
      .clk    (clk),
      .rst_n  (rst_n),
      .active (err_s),
      .count  (run_cnt)
   );

   generate
      for (genvar g = 0; g < NBINS; g++) begin : g_bin
         psg_bin #(.CNT_W(CNT_W), .TH(th_of(g))) u_bin (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (snap_clr),
            .count (run_cnt),
            .flag  (flags[g])
         );
      end
   endgenerate

   assign slip_flag = flags;
endmodule

// File: rtl/psg_chk.sv
module psg_chk #(
   parameter int TH_B0 = 8,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             clr,
   input logic             err_s,
   input logic [CNT_W-1:0] run_cnt,
   input logic [3:0]       flags
);
   p_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !clr |=> ((flags & $past(flags)) == $past(flags)));

   p_clear_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && run_cnt == '0) |=> (flags == 4'b0000));

   p_nested_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!flags[2] || flags[1]) && (!flags[1] || flags[0]) && (!flags[0] || flags[3]));

   p_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !err_s |=> (run_cnt == '0));

   p_rise_cause_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[0]) |-> ($past(run_cnt) > CNT_W'(TH_B0)));
endmodule

bind phase_slip_grader psg_chk #(.TH_B0(TH_B0), .CNT_W(CNT_W)) u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .clr     (snap_clr),
   .err_s   (err_s),
   .run_cnt (run_cnt),
   .flags   (flags)
);

// File: tb/sim_phase_slip_grader.sv
module sim_phase_slip_grader;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       err_in = 1'b0;
   logic       snap_clr = 1'b0;
   logic [3:0] slip_flag;
   int         n_run = 0;
   int         n_fail = 0;
   logic [3:0] model = 4'b0000;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   phase_slip_grader u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .err_in    (err_in),
      .snap_clr  (snap_clr),
      .slip_flag (slip_flag)
   );

   function automatic logic [3:0] grade(input int w);
      logic [3:0] r;
      r[3] = (w > 4);
      r[0] = (w > 8);
      r[1] = (w > 16);
      r[2] = (w > 24);
      return r;
   endfunction

   task automatic check(input string req, input logic [3:0] exp);
      n_run++;
      if (slip_flag !== exp) begin
         n_fail++;
         $display("FAIL %s: slip_flag=%b expected=%b", req, slip_flag, exp);
      end
   endtask

   task automatic pulse(input int w);
      @(negedge clk) err_in = 1'b1;
      repeat (w) @(negedge clk);
      err_in = 1'b0;
      repeat (4) @(negedge clk);
      model = model | grade(w);
   endtask

   task automatic clear();
      @(negedge clk) snap_clr = 1'b1;
      @(negedge clk) snap_clr = 1'b0;
      model = 4'b0000;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL watchdog: actual=hung expected=finished");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd1234));
      repeat (3) @(negedge clk);
      check("R9 reset", 4'b0000);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check("R9 after release", 4'b0000);

      // R1/R2: each threshold at its exact value and one past it
      begin
         int ths[4] = '{4, 8, 16, 24};
         foreach (ths[i]) begin
            clear();
            pulse(ths[i]);
            check("R2 width at threshold", grade(ths[i]));
            clear();
            pulse(ths[i] + 1);
            check("R1 width past threshold", grade(ths[i] + 1));
         end
      end

      // R3: flags hold through later short pulses
      clear();
      pulse(20);
      pulse(2);
      pulse(6);
      repeat (10) @(negedge clk);
      check("R3 sticky", 4'b1011);

      // R4: idle clear
      clear();
      @(negedge clk);
      check("R4 idle clear", 4'b0000);

      // R8: split pulses not summed
      @(negedge clk) err_in = 1'b1;
      repeat (5) @(negedge clk);
      err_in = 1'b0;
      @(negedge clk) err_in = 1'b1;
      repeat (5) @(negedge clk);
      err_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R8 no accumulation", 4'b1000);

      // R6: clear during a pulse already past 8 but below 16
      clear();
      @(negedge clk) err_in = 1'b1;
      repeat (12) @(negedge clk);
      snap_clr = 1'b1;
      @(negedge clk) snap_clr = 1'b0;
      check("R6 set wins over clear", 4'b1001);
      err_in = 1'b0;
      repeat (4) @(negedge clk);
      check("R6 after pulse", 4'b1001);

      // R7: saturation on a very long pulse
      clear();
      @(negedge clk) err_in = 1'b1;
      repeat (200) @(negedge clk);
      snap_clr = 1'b1;
      @(negedge clk) snap_clr = 1'b0;
      check("R7 saturated count", 4'b1111);
      repeat (40) @(negedge clk);
      check("R7 still set", 4'b1111);
      err_in = 1'b0;
      repeat (4) @(negedge clk);
      clear();
      @(negedge clk);
      check("R4 clear after saturation", 4'b0000);

      // random widths with occasional snapshots
      model = 4'b0000;
      for (int k = 0; k < 60; k++) begin
         int w = $urandom_range(1, 30);
         pulse(w);
         check("R1 R3 random", model);
         if ($urandom_range(0, 3) == 0) begin
            clear();
            @(negedge clk);
            check("R4 random clear", 4'b0000);
         end
      end

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end
endmodule